// File: doc/BRIEF.md
# Flow-Through Burst SRAM With Zero-Turnaround Pipelining

This block is a synthesizable cycle model of a small synchronous static RAM: 64 words of 16 bits, written a byte at a time and read with no output register. Every control input is sampled on the rising clock edge, and only when the active-low clock enable is low. An access begins with a load edge. After that, each advance edge steps a two-bit burst counter through four beats. The counter order is either linear or interleaved.

Reads are flow-through: the addressed word reaches the output in the same cycle that follows the edge that selected it. A write beat takes its data one enabled edge later. A read may therefore follow a write on the very next edge with no idle cycle, and it sees the newly written word.

The output is a plain data bus paired with a drive flag instead of a tri-state net. The flag plays the role of the output valid. There is no ready: the memory cannot apply back-pressure, and a consumer that cannot accept a beat holds the clock enable high instead. That freezes the whole pipeline, including any write still waiting for its data.

Top module: `ft_burst_sram`

## Requirements
- R1: A rising edge with `clk_en_n` high changes nothing: the burst state, the beat address, the access type and the memory contents all stay as they were, and a write beat still waiting for its data stays waiting.
- R2: An access starts only at an edge where `clk_en_n` is low, `load_n` is low, `sel1_n` is low, `sel2` is high and `sel3_n` is low. If any one of the three selects is inactive, no access starts.
- R3: In an access, `write_n` high makes every beat a read and `write_n` low makes every beat a write. `byte_wr_n[i]` low writes byte lane i, which is bits [8i+7:8i] of the word. A lane whose bit is high keeps its old value.
- R4: During a read beat, the word at the beat address appears on `rd_data` in the cycle right after the edge that selected that beat. `rd_drive` is high only during read beats while `out_en_n` is low. `out_en_n` acts without waiting for a clock edge. Whenever `rd_drive` is low, `rd_data` is zero.
- R5: A load edge (enabled, `load_n` low) with any select inactive ends the current access, and `rd_drive` is low in the following cycle.
- R6: After a deselect, advance edges do not start a new access, even with all selects active. Only a load edge with all selects active starts one.
- R7: The access type and the burst order are captured at the load edge. `write_n` and `burst_order` on later advance edges of the same burst have no effect.
- R8: An enabled edge with `load_n` high advances the burst whatever the selects and `write_n` show. The beat address keeps the upper four bits of the loaded address. Its two low bits are the start value plus the beat count modulo 4 when `burst_order` is 0, and the start value XOR the beat count when it is 1. The sequence wraps to the first beat after the fourth.
- R9: The data for a write beat is taken from `wr_data` at the next enabled edge after the edge that selected the beat, with `byte_wr_n` sampled at that same edge. A read of the same address loaded at that edge returns the new data in the following cycle.
- R10: `rst` is synchronous and active-high. It leaves the block deselected with `rd_drive` low and clears every memory word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock qualifier for all synchronous inputs |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: load address and start or end an access; high: advance the burst |
| write_n | input | 1 | Access type at load: high read, low write |
| byte_wr_n | input | 2 | Per-lane write selects, active low, sampled with write data |
| addr | input | 6 | Word address captured at a load edge |
| burst_order | input | 1 | 0 linear, 1 interleaved; captured at a load edge |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wr_data | input | 16 | Write data for the beat selected one enabled edge earlier |
| rd_data | output | 16 | Read data, zero when not driven |
| rd_drive | output | 1 | Read data valid / output driven flag |

## Verification
The hardest case to reach is a write beat whose data edge is delayed by one or more stalled edges, followed by a read of the same address loaded on the very edge that finally commits the data. Random stimulus alone seldom lines up a stall, a pending write and a matching read address. Directed sequences therefore stall mid-burst with junk data on the bus, then release the stall on the same edge that loads a read of the word just written. A long random phase follows, weighted towards enabled load and advance edges with mostly active selects. It reaches deselect-then-advance runs, interleaved wraps and partial byte writes, and a behavioural model in the bench predicts the bus and the flag every cycle.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // low two address bits of a beat, from the loaded start bits and beat count
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input burst_order_e ord);
    if (ord == ORD_INTERLEAVE) return start ^ step;
    return start + step;
  endfunction

endpackage

// File: rtl/ft_burst_ctrl.sv
module ft_burst_ctrl
  import ft_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en_n,
  input  logic          sel_all,
  input  logic          load_n,
  input  logic          write_n,
  input  logic          order,
  input  logic [AW-1:0] addr,
  output logic          active,
  output logic          is_write,
  output logic [AW-1:0] beat_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  burst_order_e  ord_q;
  logic          active_q;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      step_q   <= '0;
      ord_q    <= ORD_LINEAR;
    end else if (!clk_en_n) begin
      if (!load_n) begin
        active_q <= sel_all;
        if (sel_all) begin
          base_q <= addr;
          wr_q   <= !write_n;
          ord_q  <= burst_order_e'(order);
          step_q <= '0;
        end
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign active    = active_q;
  assign is_write  = wr_q;
  assign beat_addr = {base_q[AW-1:2], beat_low(base_q[1:0], step_q, ord_q)};

  a_r1_stall_holds: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(active) && $stable(is_write) && $stable(beat_addr));

  a_r2_load_starts: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && sel_all) |=> active);

  a_r5_load_deselects: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && !sel_all) |=> !active);

  a_r7_type_frozen: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n) |=> $stable(is_write) && $stable(active));

  a_r8_advance_steps: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && active) |=>
      $stable(beat_addr[AW-1:2]) && !$stable(beat_addr[1:0]));

endmodule

// File: rtl/ft_burst_array.sv
module ft_burst_array #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [DW/BW-1:0] wbe,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  localparam int NB    = DW / BW;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (wr_en && wbe[g]) begin
        lane_mem[waddr] <= wdata[g*BW +: BW];
      end
    end

    assign rdata[g*BW +: BW] = lane_mem[raddr];

    // R9: a lane write is visible on the read side right after its edge
    a_r9_lane_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wbe[g]) |=>
        (raddr != $past(waddr)) || (rdata[g*BW +: BW] == $past(wdata[g*BW +: BW])));
  end

endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram
  import ft_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             load_n,
  input  logic             write_n,
  input  logic [DW/BW-1:0] byte_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_order,
  input  logic             out_en_n,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);

  localparam int NB = DW / BW;

  logic          sel_all;
  logic          active;
  logic          is_write;
  logic [AW-1:0] beat_addr;
  logic          commit;
  logic [DW-1:0] arr_q;
  logic [NB-1:0] lane_en;

  assign sel_all = !sel1_n && sel2 && !sel3_n;

  ft_burst_ctrl #(.AW(AW)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .sel_all   (sel_all),
    .load_n    (load_n),
    .write_n   (write_n),
    .order     (burst_order),
    .addr      (addr),
    .active    (active),
    .is_write  (is_write),
    .beat_addr (beat_addr)
  );

  // a write beat takes its data on the next enabled edge
  assign commit  = active && is_write && !clk_en_n;
  assign lane_en = ~byte_wr_n;

  ft_burst_array #(.AW(AW), .DW(DW), .BW(BW)) i_array (
    .clk   (clk),
    .rst   (rst),
    .wr_en (commit),
    .waddr (beat_addr),
    .wbe   (lane_en),
    .wdata (wr_data),
    .raddr (beat_addr),
    .rdata (arr_q)
  );

  always_comb begin
    rd_drive = active && !is_write && !out_en_n;
    rd_data  = rd_drive ? arr_q : '0;
  end

  a_r4_oe_gates: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rd_drive);

  a_r5_hiz_after_deselect: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && !sel_all) |=> !rd_drive);

  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !rd_drive);

  a_r3_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && sel_all && !write_n) |=> !rd_drive);

endmodule

// File: tb/test_ft_burst_sram.sv
`timescale 1ns/1ps
module test_ft_burst_sram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en_n = 1'b1;
  logic        sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic        load_n = 1'b1, write_n = 1'b1;
  logic [1:0]  byte_wr_n = 2'b11;
  logic [5:0]  addr = '0;
  logic        burst_order = 1'b0;
  logic        out_en_n = 1'b1;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_drive;

  always #2.5 clk = ~clk;

  ft_burst_sram i_ft_burst_sram (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .load_n(load_n), .write_n(write_n), .byte_wr_n(byte_wr_n),
    .addr(addr), .burst_order(burst_order), .out_en_n(out_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // behavioural reference
  int   m_mem [64];
  bit   m_act, m_wr, m_ord;
  int   m_base, m_step;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;
  string tag = "R10";

  function automatic int m_cur();
    int lo;
    lo = m_ord ? ((m_base & 3) ^ m_step) : (((m_base & 3) + m_step) % 4);
    return (m_base & 'h3C) | lo;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_wr = 0; m_base = 0; m_step = 0; m_ord = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else if (!clk_en_n) begin
      if (m_act && m_wr) begin
        if (!byte_wr_n[0]) m_mem[m_cur()] = (m_mem[m_cur()] & 'hFF00) | int'(wr_data[7:0]);
        if (!byte_wr_n[1]) m_mem[m_cur()] = (m_mem[m_cur()] & 'h00FF) | (int'(wr_data[15:8]) << 8);
      end
      if (!load_n) begin
        if (!sel1_n && sel2 && !sel3_n) begin
          m_act = 1; m_base = int'(addr); m_wr = !write_n; m_ord = burst_order; m_step = 0;
        end else m_act = 0;
      end else m_step = (m_step + 1) % 4;
    end
  end

  task automatic compare();
    bit   ev;
    int   ed;
    ev = m_act && !m_wr && !out_en_n;
    ed = ev ? m_mem[m_cur()] : 0;
    n_cmp++;
    if (rd_drive !== ev || int'(rd_data) != ed || $isunknown(rd_data)) begin
      n_bad++;
      $display("FAIL %s: drive=%0b data=%04h expected drive=%0b data=%04h at %0t",
               tag, rd_drive, rd_data, ev, ed[15:0], $time);
    end
  endtask

  // set the inputs for the next edge, then check the result after it
  task automatic op(input bit cen, input bit [2:0] ce, input bit ld, input bit we,
                    input bit [1:0] bw, input bit [5:0] a, input bit ord,
                    input bit oe, input bit [15:0] wd);
    clk_en_n = cen; sel1_n = ~ce[0]; sel2 = ce[1]; sel3_n = ~ce[2];
    load_n = ld; write_n = we; byte_wr_n = bw; addr = a; burst_order = ord;
    out_en_n = oe; wr_data = wd;
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    // R10: reset leaves the output idle
    tag = "R10";
    op(0, 7, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 7, 0, 1, 3, 6'h05, 0, 0, 0);
    rst = 1'b0;
    op(0, 7, 0, 1, 3, 6'h05, 0, 0, 0);   // read of cleared word gives 0
    // R3 R9: linear write burst from 0x05, partial lane on third beat
    tag = "R3 R9";
    op(0, 7, 0, 0, 3, 6'h05, 0, 0, 16'h0);
    op(0, 7, 1, 1, 2'b00, 0, 1, 0, 16'hA105);
    op(0, 7, 1, 1, 2'b00, 0, 1, 0, 16'hA206);
    op(0, 7, 1, 1, 2'b10, 0, 1, 0, 16'hA307);
    op(0, 0, 0, 1, 2'b01, 0, 0, 0, 16'hA404);
    // R4 R8: interleaved read from 0x05, output enable toggled, wrap
    tag = "R4 R8";
    op(0, 7, 0, 1, 3, 6'h05, 1, 0, 0);
    op(0, 7, 1, 1, 3, 0, 0, 0, 0);
    op(0, 7, 1, 1, 3, 0, 0, 1, 0);
    out_en_n = 1'b0; #0.5; compare();    // R4: out_en_n acts without an edge
    op(0, 7, 1, 1, 3, 0, 0, 0, 0);
    op(0, 7, 1, 1, 3, 0, 0, 0, 0);       // wraps to 0x05
    // R7: write_n and order ignored on advances
    tag = "R7";
    op(0, 7, 0, 0, 3, 6'h22, 0, 0, 0);
    op(0, 7, 1, 1, 2'b00, 0, 1, 0, 16'h7001);
    op(0, 7, 0, 1, 2'b00, 6'h22, 0, 0, 16'h7002);
    op(0, 7, 1, 0, 3, 0, 1, 0, 0);
    op(0, 7, 1, 0, 3, 0, 1, 0, 0);
    // R9: read loaded on the write data edge sees the new word
    tag = "R9";
    op(0, 7, 0, 0, 3, 6'h11, 0, 0, 0);
    op(0, 7, 0, 1, 2'b00, 6'h11, 0, 0, 16'hBEEF);
    // R1: stall with a write waiting, junk data ignored
    tag = "R1";
    op(0, 7, 0, 0, 3, 6'h30, 0, 0, 0);
    op(1, 0, 0, 1, 2'b00, 6'h3F, 1, 0, 16'hDEAD);
    op(1, 7, 1, 1, 2'b00, 6'h3F, 1, 0, 16'hDEAD);
    op(0, 7, 0, 1, 2'b00, 6'h30, 0, 0, 16'h1234);
    op(1, 7, 0, 1, 3, 6'h31, 0, 0, 0);
    op(0, 7, 1, 1, 3, 0, 0, 0, 0);
    // R5 R6: deselect, then advances do not restart
    tag = "R5 R6";
    op(0, 7, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 3'b110, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 7, 1, 1, 3, 6'h05, 0, 0, 0);
    op(0, 7, 1, 0, 3, 6'h05, 0, 0, 0);
    op(0, 7, 0, 1, 3, 6'h06, 0, 0, 0);
    // R2: each select alone blocks a start
    tag = "R2";
    op(0, 3'b110, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 3'b101, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 3'b011, 0, 1, 3, 6'h05, 0, 0, 0);
    op(0, 7, 0, 1, 3, 6'h05, 0, 0, 0);
    // random mix: R2 R3 R8 R9
    tag = "R2 R3 R8 R9";
    for (int k = 0; k < 4000; k++) begin
      bit [2:0] ce;
      int       p;
      p  = $urandom % 10;
      ce = (p < 8) ? 3'b111 : (3'b111 & ~(3'b1 << ($urandom % 3)));
      op(($urandom % 8) == 0, ce, ($urandom % 5) < 2, $urandom % 2,
         2'($urandom), 6'($urandom % 16), $urandom % 2, ($urandom % 8) == 0,
         16'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule